// File: doc/BRIEF.md
# Index-Invalidated Translation Lookaside Buffer

This block caches page translations in front of a page table walker. A lookup presents a 32-bit effective address and a segment identifier. If the cached entry at the indexed slot holds a matching tag, the physical address and memory attributes are returned on the next cycle. If it does not, the block requests a fill from the walker, installs the returned page number and attributes, and answers the lookup once the walker acknowledges. A block-address-translation hit signalled alongside the lookup takes priority: its result is returned directly and the cache is left untouched.

Software has no path to read or write an entry. It can only invalidate the slot selected by effective address bits [17:12], and it can request a sync. The sync reports completion once every invalidation issued before it, or in the same cycle, has taken effect. Stepping the address by 0x1000 sixty-four times therefore empties the whole cache.

The lookup controller is a two-state machine. READY accepts lookups. On a lookup that misses both the cache and the block translation, the transition "miss" goes to WALK. WALK holds the walker request. The transition "fill" returns to READY on the walker acknowledge, and in that same cycle the entry is written. A block-translation hit or a cache hit keeps the machine in READY.

Top module: `tlb_index_inval`

## Requirements
- R1: After reset every slot is invalid, so the first lookup to any index misses. At reset `lk_ready`=1 and `rsp_valid`, `walk_req` and `sync_done` are 0.
- R2: A lookup accepted in cycle t that hits gives `rsp_valid`=1 and `rsp_bat`=0 in cycle t+1. In that cycle `rsp_pa` = {cached page number, lookup ea[11:0]}, and `rsp_wimg`/`rsp_pp` carry the cached attributes. No walk is requested.
- R3: A lookup accepted in cycle t that misses raises `walk_req` from cycle t+1. `walk_ea` and `walk_vsid` equal the lookup values. The request holds steady until `walk_ack`, and `lk_ready` stays 0 meanwhile.
- R4: `walk_ack` while `walk_req` is high installs the entry at index ea[17:12]. The next cycle gives `rsp_valid`, `rsp_bat`=0, `rsp_pa` = {`walk_rpn`, ea[11:0]} and the walker's attributes, and the block returns to READY.
- R5: A hit requires both the stored segment identifier and ea[31:18] to match. A lookup with the same index but any other tag misses.
- R6: `inv_valid` in cycle t clears only the slot at `inv_ea`[17:12]. Lookups accepted from cycle t+2 onward see that slot empty, and other slots are unaffected.
- R7: `sync_done` is a one-cycle pulse. It comes in the first cycle after `sync_req` in which no invalidation is still pending, and it is never high in the cycle after an `inv_valid`. A sync with nothing pending completes one cycle after the request.
- R8: When `bat_hit` accompanies an accepted lookup, the next cycle returns `bat_pa`, `bat_wimg` and `bat_pp` with `rsp_bat`=1. No walk is started and no slot changes.
- R9: If an invalidation takes effect in the same cycle as a fill to the same slot, the slot ends invalid. A fill to a different slot in that cycle still completes.
- R10: Sixty-four invalidations at addresses stepped by 0x1000 leave every slot invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_vsid | input | 24 | Lookup segment identifier |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| bat_hit | input | 1 | Block translation matched the lookup |
| bat_pa | input | 32 | Block translation physical address |
| bat_wimg | input | 4 | Block translation storage attributes |
| bat_pp | input | 2 | Block translation protection bits |
| inv_valid | input | 1 | Invalidate-by-index command |
| inv_ea | input | 32 | Address whose bits [17:12] pick the slot |
| sync_req | input | 1 | Sync command |
| sync_done | output | 1 | Sync completion pulse |
| walk_req | output | 1 | Fill request to the walker |
| walk_ea | output | 32 | Address to translate |
| walk_vsid | output | 24 | Segment identifier to translate |
| walk_ack | input | 1 | Walker returns a translation |
| walk_rpn | input | 20 | Returned physical page number |
| walk_wimg | input | 4 | Returned storage attributes |
| walk_pp | input | 2 | Returned protection bits |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_bat | output | 1 | Result came from block translation |
| rsp_pa | output | 32 | Physical address |
| rsp_wimg | output | 4 | Storage attributes |
| rsp_pp | output | 2 | Protection bits |

## Verification
A fill from the walker and an invalidation of the same slot can take effect on the same clock edge. The bench provokes this by holding a miss in WALK, issuing the invalidation one cycle before raising `walk_ack`, and then looking up the same page again. A second miss shows that the invalidation won. A control run aims the invalidation at a neighbouring slot and expects the fill to survive as a hit. A sync issued together with the last of a burst of invalidations is checked for a low `sync_done` in the next cycle, a single pulse in the one after, and then a sweep in which exactly the cleared slots miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int EA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int RPN_W  = EA_W - OFS_W;
    localparam int WIMG_W = 4;
    localparam int PP_W   = 2;

    typedef struct packed {
        logic [WIMG_W-1:0] wimg;
        logic [PP_W-1:0]   pp;
    } tlb_attr_t;

    typedef enum logic [0:0] {
        S_READY = 1'b0,
        S_WALK  = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [RPN_W-1:0]  rd_rpn,
    output tlb_attr_t         rd_attr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [RPN_W-1:0]  wr_rpn,
    input  tlb_attr_t         wr_attr,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] vld_q;
    logic [TAG_W-1:0] tag_q  [SLOTS];
    logic [RPN_W-1:0] rpn_q  [SLOTS];
    tlb_attr_t        attr_q [SLOTS];

    // Clearing beats filling when both target one slot.
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q[gi] <= 1'b0;
            else if (clr_en && clr_idx == IDX_W'(gi))
                vld_q[gi] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(gi))
                vld_q[gi] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            rpn_q[wr_idx]  <= wr_rpn;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_rpn   = rpn_q[rd_idx];
    assign rd_attr  = attr_q[rd_idx];
endmodule

// File: rtl/tlb_inval_seq.sv
module tlb_inval_seq #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_valid,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             sync_req,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             sync_done
);
    logic sync_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_en      <= 1'b0;
            clr_idx     <= '0;
            sync_pend_q <= 1'b0;
        end else begin
            clr_en      <= inv_valid;
            clr_idx     <= inv_idx;
            sync_pend_q <= (sync_pend_q && !sync_done) || sync_req;
        end
    end

    // Completion waits until the staged clear has been applied.
    assign sync_done = sync_pend_q && !clr_en;
endmodule

// File: rtl/tlb_lookup_fsm.sv
module tlb_lookup_fsm
    import tlb_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int VSID_W = 24,
    parameter int TAG_W  = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [EA_W-1:0]   lk_ea,
    input  logic [VSID_W-1:0] lk_vsid,
    output logic              lk_ready,
    input  logic              bat_hit,
    input  logic [EA_W-1:0]   bat_pa,
    input  tlb_attr_t         bat_attr,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [RPN_W-1:0]  rd_rpn,
    input  tlb_attr_t         rd_attr,
    output logic              walk_req,
    output logic [EA_W-1:0]   walk_ea,
    output logic [VSID_W-1:0] walk_vsid,
    input  logic              walk_ack,
    input  logic [RPN_W-1:0]  walk_rpn,
    input  tlb_attr_t         walk_attr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [RPN_W-1:0]  wr_rpn,
    output tlb_attr_t         wr_attr,
    output logic              rsp_valid,
    output logic              rsp_bat,
    output logic [EA_W-1:0]   rsp_pa,
    output tlb_attr_t         rsp_attr
);
    localparam int TOP_LSB = OFS_W + IDX_W;

    tlb_state_e state_q, state_d;
    logic       lk_fire, tag_hit;

    assign lk_ready = (state_q == S_READY);
    assign walk_req = (state_q == S_WALK);
    assign lk_fire  = lk_valid && lk_ready;
    assign tag_hit  = rd_valid && (rd_tag == {lk_vsid, lk_ea[EA_W-1:TOP_LSB]});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_READY: if (lk_fire && !bat_hit && !tag_hit) state_d = S_WALK;
            S_WALK:  if (walk_ack)                        state_d = S_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_bat   <= 1'b0;
            rsp_pa    <= '0;
            rsp_attr  <= '0;
            walk_ea   <= '0;
            walk_vsid <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                S_READY: begin
                    if (lk_fire && bat_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_bat   <= 1'b1;
                        rsp_pa    <= bat_pa;
                        rsp_attr  <= bat_attr;
                    end else if (lk_fire && tag_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_bat   <= 1'b0;
                        rsp_pa    <= {rd_rpn, lk_ea[OFS_W-1:0]};
                        rsp_attr  <= rd_attr;
                    end else if (lk_fire) begin
                        walk_ea   <= lk_ea;
                        walk_vsid <= lk_vsid;
                    end
                end
                S_WALK: begin
                    if (walk_ack) begin
                        rsp_valid <= 1'b1;
                        rsp_bat   <= 1'b0;
                        rsp_pa    <= {walk_rpn, walk_ea[OFS_W-1:0]};
                        rsp_attr  <= walk_attr;
                    end
                end
            endcase
        end
    end

    assign wr_en   = walk_req && walk_ack;
    assign wr_idx  = walk_ea[OFS_W +: IDX_W];
    assign wr_tag  = {walk_vsid, walk_ea[EA_W-1:TOP_LSB]};
    assign wr_rpn  = walk_rpn;
    assign wr_attr = walk_attr;
endmodule

// File: rtl/tlb_index_inval.sv
module tlb_index_inval
    import tlb_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int VSID_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_ea,
    input  logic [VSID_W-1:0] lk_vsid,
    output logic              lk_ready,
    input  logic              bat_hit,
    input  logic [31:0]       bat_pa,
    input  logic [3:0]        bat_wimg,
    input  logic [1:0]        bat_pp,
    input  logic              inv_valid,
    input  logic [31:0]       inv_ea,
    input  logic              sync_req,
    output logic              sync_done,
    output logic              walk_req,
    output logic [31:0]       walk_ea,
    output logic [VSID_W-1:0] walk_vsid,
    input  logic              walk_ack,
    input  logic [19:0]       walk_rpn,
    input  logic [3:0]        walk_wimg,
    input  logic [1:0]        walk_pp,
    output logic              rsp_valid,
    output logic              rsp_bat,
    output logic [31:0]       rsp_pa,
    output logic [3:0]        rsp_wimg,
    output logic [1:0]        rsp_pp
);
    localparam int TAG_W = VSID_W + EA_W - OFS_W - IDX_W;

    logic             rd_valid, wr_en, clr_en;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic [RPN_W-1:0] rd_rpn, wr_rpn;
    logic [IDX_W-1:0] wr_idx, clr_idx;
    tlb_attr_t        rd_attr, wr_attr, rsp_attr;
    logic             unused_inv_bits;

    assign unused_inv_bits = ^{inv_ea[EA_W-1:OFS_W+IDX_W], inv_ea[OFS_W-1:0]};
    assign rsp_wimg = rsp_attr.wimg;
    assign rsp_pp   = rsp_attr.pp;

    tlb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_ea[OFS_W +: IDX_W]),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_rpn(rd_rpn), .rd_attr(rd_attr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_rpn(wr_rpn), .wr_attr(wr_attr),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    tlb_inval_seq #(.IDX_W(IDX_W)) u_inval (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_idx(inv_ea[OFS_W +: IDX_W]),
        .sync_req(sync_req),
        .clr_en(clr_en), .clr_idx(clr_idx), .sync_done(sync_done)
    );

    tlb_lookup_fsm #(.IDX_W(IDX_W), .VSID_W(VSID_W), .TAG_W(TAG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_vsid(lk_vsid), .lk_ready(lk_ready),
        .bat_hit(bat_hit), .bat_pa(bat_pa),
        .bat_attr('{wimg: bat_wimg, pp: bat_pp}),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_rpn(rd_rpn), .rd_attr(rd_attr),
        .walk_req(walk_req), .walk_ea(walk_ea), .walk_vsid(walk_vsid),
        .walk_ack(walk_ack), .walk_rpn(walk_rpn),
        .walk_attr('{wimg: walk_wimg, pp: walk_pp}),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_rpn(wr_rpn), .wr_attr(wr_attr),
        .rsp_valid(rsp_valid), .rsp_bat(rsp_bat), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr)
    );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic        bat_hit,
    input logic [31:0] bat_pa,
    input logic        inv_valid,
    input logic        sync_done,
    input logic        walk_req,
    input logic        walk_ack,
    input logic [31:0] walk_ea,
    input logic [19:0] walk_rpn,
    input logic        rsp_valid,
    input logic        rsp_bat,
    input logic [31:0] rsp_pa
);
    assert_bat_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && bat_hit) |=>
            (rsp_valid && rsp_bat && rsp_pa == $past(bat_pa) && !walk_req));

    assert_walk_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_ea)));

    assert_busy_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !lk_ready);

    assert_fill_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_ack) |=>
            (rsp_valid && !rsp_bat && !walk_req &&
             rsp_pa == {$past(walk_rpn), $past(walk_ea[11:0])}));

    assert_sync_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !sync_done);

    assert_sync_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> !sync_done);
endmodule

bind tlb_index_inval tlb_checker u_tlb_checker (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .bat_hit(bat_hit), .bat_pa(bat_pa), .inv_valid(inv_valid), .sync_done(sync_done),
    .walk_req(walk_req), .walk_ack(walk_ack), .walk_ea(walk_ea), .walk_rpn(walk_rpn),
    .rsp_valid(rsp_valid), .rsp_bat(rsp_bat), .rsp_pa(rsp_pa)
);

// File: tb/tb_tlb_index_inval.sv
module tb_tlb_index_inval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [23:0] lk_vsid = '0;
    logic        lk_ready;
    logic        bat_hit = 1'b0;
    logic [31:0] bat_pa = '0;
    logic [3:0]  bat_wimg = '0;
    logic [1:0]  bat_pp = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_ea = '0;
    logic        sync_req = 1'b0;
    logic        sync_done;
    logic        walk_req;
    logic [31:0] walk_ea;
    logic [23:0] walk_vsid;
    logic        walk_ack = 1'b0;
    logic [19:0] walk_rpn = '0;
    logic [3:0]  walk_wimg = '0;
    logic [1:0]  walk_pp = '0;
    logic        rsp_valid, rsp_bat;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_wimg;
    logic [1:0]  rsp_pp;

    always #4 clk = ~clk;

    tlb_index_inval dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 0;
    int fill_seq = 0;

    bit          m_vld  [64];
    logic [37:0] m_tag  [64];
    logic [19:0] m_rpn  [64];
    logic [5:0]  m_attr [64];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            finish_run();
        end
    end

    // Lookup with expectation from the bench model; misses are served by the walker model.
    task automatic look(input logic [31:0] ea, input logic [23:0] vs, input bit use_bat, input string req);
        int  ix = int'(ea[17:12]);
        bit  hit = m_vld[ix] && m_tag[ix] == {vs, ea[31:18]};
        logic [19:0] rpn;
        logic [5:0]  at;
        @(negedge clk);
        lk_valid = 1; lk_ea = ea; lk_vsid = vs; bat_hit = use_bat;
        bat_pa = ea ^ 32'hA5A0_0000; bat_wimg = 4'h9; bat_pp = 2'b01;
        @(negedge clk);
        lk_valid = 0; bat_hit = 0;
        if (use_bat) begin
            chk(rsp_valid && rsp_bat && !walk_req && rsp_pa == (ea ^ 32'hA5A0_0000)
                && rsp_wimg == 4'h9 && rsp_pp == 2'b01, {req, " R8 block result"},
                {rsp_valid, rsp_bat, walk_req, rsp_pa}, {3'b110, ea ^ 32'hA5A0_0000});
        end else if (hit) begin
            chk(rsp_valid && !rsp_bat && !walk_req && rsp_pa == {m_rpn[ix], ea[11:0]}
                && {rsp_wimg, rsp_pp} == m_attr[ix], {req, " R2 hit"},
                {rsp_valid, walk_req, rsp_wimg, rsp_pp, rsp_pa}, {2'b10, m_attr[ix], m_rpn[ix], ea[11:0]});
        end else begin
            chk(walk_req && !rsp_valid && !lk_ready && walk_ea == ea && walk_vsid == vs,
                {req, " R3 miss walk"}, {walk_req, rsp_valid, lk_ready, walk_vsid, walk_ea},
                {3'b100, vs, ea});
            fill_seq++;
            rpn = 20'hB0000 + 20'(fill_seq * 7);
            at  = 6'(fill_seq * 5);
            walk_ack = 1; walk_rpn = rpn; walk_wimg = at[5:2]; walk_pp = at[1:0];
            @(negedge clk);
            walk_ack = 0;
            chk(rsp_valid && !rsp_bat && !walk_req && lk_ready && rsp_pa == {rpn, ea[11:0]}
                && {rsp_wimg, rsp_pp} == at, {req, " R4 fill reply"},
                {rsp_valid, walk_req, rsp_wimg, rsp_pp, rsp_pa}, {2'b10, at, rpn, ea[11:0]});
            m_vld[ix] = 1; m_tag[ix] = {vs, ea[31:18]}; m_rpn[ix] = rpn; m_attr[ix] = at;
        end
    endtask

    function automatic logic [31:0] pg(input logic [13:0] hi, input int ix, input logic [11:0] ofs);
        return {hi, 6'(ix), ofs};
    endfunction

    localparam logic [23:0] VS0 = 24'h3C_1A27;

    initial begin
        for (int i = 0; i < 64; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(lk_ready && !rsp_valid && !walk_req && !sync_done, "R1 reset outputs",
            {lk_ready, rsp_valid, walk_req, sync_done}, 4'b1000);
        rst_n = 1;

        // R1/R3/R4: every slot misses after reset and gets filled
        for (int i = 0; i < 64; i++) look(pg(14'h0A5, i, 12'(i * 61)), VS0, 0, "R1 first sweep");
        // R2: every slot hits at a different offset
        for (int i = 0; i < 64; i++) look(pg(14'h0A5, i, 12'(4095 - i)), VS0, 0, "R2 hit sweep");

        // R5: tag mismatch on upper address bits and on segment identifier
        look(pg(14'h1111, 7, 12'h020), VS0, 0, "R5 upper bits differ");
        look(pg(14'h0A5, 7, 12'h024), VS0, 0, "R5 old tag evicted");
        look(pg(14'h0A5, 9, 12'h030), VS0 ^ 24'h1, 0, "R5 vsid differs");
        look(pg(14'h0A5, 9, 12'h034), VS0 ^ 24'h1, 0, "R5 refilled hit");

        // R8: block translation wins on a hit slot and on a slot that would miss
        look(pg(14'h0A5, 3, 12'h100), VS0, 1, "R8 over hit");
        look(pg(14'h0A5, 3, 12'h104), VS0, 0, "R8 slot unchanged");
        look(pg(14'h2222, 4, 12'h108), VS0, 1, "R8 over miss");
        look(pg(14'h0A5, 4, 12'h10C), VS0, 0, "R8 no fill happened");

        // R6/R7: invalidate even slots, sync issued with the last one
        for (int i = 0; i < 64; i += 2) begin
            @(negedge clk);
            inv_valid = 1; inv_ea = pg(14'h3FFF - 14'(i), i, 12'hABC);
            sync_req = (i == 62);
            m_vld[i] = 0;
        end
        @(negedge clk);
        inv_valid = 0; sync_req = 0;
        chk(!sync_done, "R7 sync held by pending invalidation", {63'd0, sync_done}, 64'd0);
        @(negedge clk);
        chk(sync_done, "R7 sync completes", {63'd0, sync_done}, 64'd1);
        @(negedge clk);
        chk(!sync_done, "R7 sync is one pulse", {63'd0, sync_done}, 64'd0);
        for (int i = 0; i < 64; i++) look(pg(14'h0A5, i, 12'h77), VS0, 0, "R6 partial clear sweep");

        // R7: sync with nothing pending
        @(negedge clk);
        sync_req = 1;
        @(negedge clk);
        sync_req = 0;
        chk(sync_done, "R7 idle sync", {63'd0, sync_done}, 64'd1);
        @(negedge clk);
        chk(!sync_done, "R7 idle sync pulse", {63'd0, sync_done}, 64'd0);

        // R10: step by 0x1000 sixty-four times
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            inv_valid = 1; inv_ea = 32'h3000_0000 + 32'(i) * 32'h1000;
            sync_req = (i == 63);
            m_vld[i] = 0;
        end
        @(negedge clk);
        inv_valid = 0; sync_req = 0;
        @(negedge clk);
        chk(sync_done, "R10 sync after full clear", {63'd0, sync_done}, 64'd1);
        for (int i = 0; i < 64; i++) look(pg(14'h0A5, i, 12'h5), VS0, 0, "R10 all cleared sweep");

        // R9: invalidation and fill land on slot 5 together
        @(negedge clk);
        lk_valid = 1; lk_ea = pg(14'h01F0, 5, 12'h010); lk_vsid = VS0;
        @(negedge clk);
        lk_valid = 0;
        chk(walk_req, "R9 setup miss", {63'd0, walk_req}, 64'd1);
        inv_valid = 1; inv_ea = pg(14'h0, 5, 12'h0);
        @(negedge clk);
        inv_valid = 0;
        walk_ack = 1; walk_rpn = 20'h5_5555; walk_wimg = 4'h3; walk_pp = 2'b10;
        @(negedge clk);
        walk_ack = 0;
        chk(rsp_valid && rsp_pa == 32'h5555_5010, "R9 reply still given",
            {31'd0, rsp_valid, rsp_pa}, {31'd0, 1'b1, 32'h5555_5010});
        m_vld[5] = 0;
        look(pg(14'h01F0, 5, 12'h014), VS0, 0, "R9 collided slot invalid");

        // R9 control: invalidation on slot 6 while slot 8 fills
        @(negedge clk);
        lk_valid = 1; lk_ea = pg(14'h01F0, 8, 12'h020); lk_vsid = VS0;
        @(negedge clk);
        lk_valid = 0;
        inv_valid = 1; inv_ea = pg(14'h0, 6, 12'h0);
        @(negedge clk);
        inv_valid = 0;
        walk_ack = 1; walk_rpn = 20'h6_6666; walk_wimg = 4'h1; walk_pp = 2'b11;
        @(negedge clk);
        walk_ack = 0;
        m_vld[6] = 0;
        m_vld[8] = 1; m_tag[8] = {VS0, 14'h01F0}; m_rpn[8] = 20'h6_6666; m_attr[8] = {4'h1, 2'b11};
        look(pg(14'h01F0, 8, 12'h028), VS0, 0, "R9 other fill survives");
        look(pg(14'h0A5, 6, 12'h02C), VS0, 0, "R9 other slot cleared");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule